// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin General-Purpose I/O Bank

This block is a bank of general-purpose pins that a processor controls through word-wide register accesses. Software sets each pin's output value and output enable. It reads back the pad levels after they have been synchronized into the block's clock domain. Any pin can also be set up as an interrupt source. The bus side is a bare strobe interface: a write takes effect at the clock edge on which the write strobe is sampled, and read data is registered and returned on the following cycle.

Every pin has its own interrupt configuration held in separate bits:
- an enable bit;
- a mask bit;
- a sensitivity bit, which selects edge or level;
- a polarity bit, which selects rising/high or falling/low.

An edge event is latched until software writes a one to that pin's position in the acknowledge register. A level source reports the pin's live state and cannot be acknowledged away. Two status views are provided. The raw view shows every enabled source. The masked view drops the sources whose mask bit is set. The single interrupt line is asserted whenever any masked status bit is set.

Top module: `pinBankTop`

## Requirements
- R1: After reset every register is 0, so `padOut`, `padOe`, `irqOut` and `busRdata` are all 0.
- R2: Writing offset 0x00 sets the output values driven on `padOut`. Writing offset 0x04 sets the per-pin output enable on `padOe`, where 1 means output and 0 means input. Both offsets read back the value last written.
- R3: A read of offset 0x50 returns `padIn` after a two-flop synchronizer. A pad change made before clock edge k is visible to a read sampled at edge k+2 or later.
- R4: The sensitivity register sits at 0x38, where 1 means edge and 0 means level. The polarity register sits at 0x3C, where 1 means rising or high and 0 means falling or low. For an enabled edge pin, a synchronized transition in the selected direction sets that pin's bit in the raw status at 0x44 at the third clock edge after the pad change. The bit stays set after the pad returns.
- R5: For an enabled level pin, the raw status bit equals the synchronized pad compared against its polarity. Acknowledge writes do not clear it.
- R6: Writing offset 0x4C clears latched edge bits at the positions written as 1. Positions written as 0 are unchanged. If a new edge is detected in the same cycle as the acknowledge, the bit stays set.
- R7: Only pins whose bit is 1 in the enable register at 0x30 can show raw status. Clearing an enable bit removes that pin's latched edge from the next cycle on.
- R8: The masked status at 0x40 equals the raw status with the pins whose bit is 1 in the mask register at 0x34 removed. Masking leaves the raw status unchanged.
- R9: `irqOut` is 1 exactly when the masked status is non-zero.
- R10: Reads of 0x78, of 0x4C and of any unmapped offset return 0. Writes to 0x40, 0x44, 0x50, 0x78 and to unmapped offsets change no state.
- R11: `busRdata` is loaded with the addressed value on the edge that samples `busRdEn`, and it holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| padIn | input | 32 | Asynchronous pad input levels |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to produce is an acknowledge write that lands in the same cycle as a fresh edge on the pin it clears, because the synchronizer places the edge two cycles after the pad change. The stimulus changes the pad, counts exactly two rising clock edges, and then issues the acknowledge write so that it is sampled on the edge that also latches the new event. Further sequences switch a pin from edge to level mode while an edge is latched, disable a pin that has a pending edge, and mask pins while they are active. The cycle-accurate model checks every step of these sequences.

// File: rtl/pinBankPkg.sv
package pinBankPkg;
  localparam logic [7:0] OFF_OUT   = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_EN    = 8'h30;
  localparam logic [7:0] OFF_MASK  = 8'h34;
  localparam logic [7:0] OFF_TYPE  = 8'h38;
  localparam logic [7:0] OFF_POL   = 8'h3C;
  localparam logic [7:0] OFF_MSTAT = 8'h40;
  localparam logic [7:0] OFF_RSTAT = 8'h44;
  localparam logic [7:0] OFF_ACK   = 8'h4C;
  localparam logic [7:0] OFF_PADS  = 8'h50;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_OUT, SEL_DIR, SEL_EN, SEL_MASK,
    SEL_TYPE, SEL_POL, SEL_MSTAT, SEL_RSTAT, SEL_PADS
  } rdSel_e;

  typedef struct packed {
    logic   wrOut;
    logic   wrDir;
    logic   wrEn;
    logic   wrMask;
    logic   wrType;
    logic   wrPol;
    logic   wrAck;
    logic   rdGo;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/pinBankCtrl.sv
module pinBankCtrl
  import pinBankPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  always_comb begin
    strb = '0;
    strb.rdGo = busRdEn;
    strb.rdSel = SEL_ZERO;
    if (busAddr == ADDR_W'(OFF_OUT)) begin
      strb.wrOut = busWrEn;
      strb.rdSel = SEL_OUT;
    end else if (busAddr == ADDR_W'(OFF_DIR)) begin
      strb.wrDir = busWrEn;
      strb.rdSel = SEL_DIR;
    end else if (busAddr == ADDR_W'(OFF_EN)) begin
      strb.wrEn = busWrEn;
      strb.rdSel = SEL_EN;
    end else if (busAddr == ADDR_W'(OFF_MASK)) begin
      strb.wrMask = busWrEn;
      strb.rdSel = SEL_MASK;
    end else if (busAddr == ADDR_W'(OFF_TYPE)) begin
      strb.wrType = busWrEn;
      strb.rdSel = SEL_TYPE;
    end else if (busAddr == ADDR_W'(OFF_POL)) begin
      strb.wrPol = busWrEn;
      strb.rdSel = SEL_POL;
    end else if (busAddr == ADDR_W'(OFF_MSTAT)) begin
      strb.rdSel = SEL_MSTAT;
    end else if (busAddr == ADDR_W'(OFF_RSTAT)) begin
      strb.rdSel = SEL_RSTAT;
    end else if (busAddr == ADDR_W'(OFF_ACK)) begin
      strb.wrAck = busWrEn;
    end else if (busAddr == ADDR_W'(OFF_PADS)) begin
      strb.rdSel = SEL_PADS;
    end
  end
endmodule

// File: rtl/pinBankSync.sv
module pinBankSync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pinBankData.sv
module pinBankData
  import pinBankPkg::*;
#(
  parameter int PINS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [PINS-1:0] busWdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] busRdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] rawStat,
  output logic [PINS-1:0] maskedStat
);
  logic [PINS-1:0] outReg, dirReg, enReg, maskReg, typeReg, polReg;
  logic [PINS-1:0] edgeLatch, prevSync, padSync;
  logic [PINS-1:0] enNext, typeNext, ackBits, edgeHit, levelHit, rdValue;

  pinBankSync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (padIn),
    .dout(padSync)
  );

  assign enNext   = strb.wrEn   ? busWdata : enReg;
  assign typeNext = strb.wrType ? busWdata : typeReg;
  assign ackBits  = strb.wrAck  ? busWdata : '0;

  assign edgeHit  = (padSync & ~prevSync & polReg) | (~padSync & prevSync & ~polReg);
  assign levelHit = enReg & ~typeReg & ~(padSync ^ polReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      enReg   <= '0;
      maskReg <= '0;
      typeReg <= '0;
      polReg  <= '0;
    end else begin
      if (strb.wrOut)  outReg  <= busWdata;
      if (strb.wrDir)  dirReg  <= busWdata;
      if (strb.wrEn)   enReg   <= busWdata;
      if (strb.wrMask) maskReg <= busWdata;
      if (strb.wrType) typeReg <= busWdata;
      if (strb.wrPol)  polReg  <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeLatch <= '0;
      prevSync  <= '0;
    end else begin
      edgeLatch <= ((edgeLatch & ~ackBits) | edgeHit) & enNext & typeNext;
      prevSync  <= padSync;
    end
  end

  assign rawStat    = edgeLatch | levelHit;
  assign maskedStat = rawStat & ~maskReg;

  always_comb begin
    unique case (strb.rdSel)
      SEL_OUT:   rdValue = outReg;
      SEL_DIR:   rdValue = dirReg;
      SEL_EN:    rdValue = enReg;
      SEL_MASK:  rdValue = maskReg;
      SEL_TYPE:  rdValue = typeReg;
      SEL_POL:   rdValue = polReg;
      SEL_MSTAT: rdValue = maskedStat;
      SEL_RSTAT: rdValue = rawStat;
      SEL_PADS:  rdValue = padSync;
      default:   rdValue = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (strb.rdGo) busRdata <= rdValue;
  end

  assign padOut = outReg;
  assign padOe  = dirReg;
endmodule

// File: rtl/pinBankTop.sv
module pinBankTop
  import pinBankPkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqOut
);
  strobe_t         strb;
  logic [PINS-1:0] rawStat, maskedStat;

  pinBankCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strb   (strb)
  );

  pinBankData #(.PINS(PINS), .SYNC_STAGES(2)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .padIn     (padIn),
    .busRdata  (busRdata),
    .padOut    (padOut),
    .padOe     (padOe),
    .rawStat   (rawStat),
    .maskedStat(maskedStat)
  );

  assign irqOut = |maskedStat;
endmodule

// File: rtl/pinBankChecker.sv
module pinBankChecker #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PINS-1:0]   busWdata,
  input logic [PINS-1:0]   busRdata,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   rawStat
);
  // R1: reset clears every observable output
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (padOut == '0 && padOe == '0 && busRdata == '0));

  // R2: output data write is visible on the pads next cycle
  a_r2_out_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8'h00)) |=> (padOut == $past(busWdata)));

  // R2: direction write drives the output enables
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8'h04)) |=> (padOe == $past(busWdata)));

  // R7: after an enable write, pins left disabled show no raw status
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8'h30)) |=> ((rawStat & ~$past(busWdata)) == '0));

  // R11: read data holds when no read is strobed
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn && rstN) |=> $stable(busRdata));
endmodule

bind pinBankTop pinBankChecker #(.PINS(PINS), .ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busWrEn (busWrEn),
  .busRdEn (busRdEn),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .padOut  (padOut),
  .padOe   (padOe),
  .rawStat (rawStat)
);

// File: tb/pinBankTop_test.sv
module pinBankTop_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  string tagNow = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pinBankTop uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  // behavioural reference model
  bit [31:0] mOut, mDir, mEn, mMask, mType, mPol, mLatch, mRd;
  bit [31:0] padHist [$];   // newest at back; holds pad samples
  bit [31:0] mSync, mPrev;

  function automatic bit [31:0] modelRaw();
    bit [31:0] lvl;
    lvl = mEn & ~mType & ~(mSync ^ mPol);
    return mLatch | lvl;
  endfunction

  function automatic bit [31:0] modelRead(input bit [7:0] a);
    case (a)
      8'h00: return mOut;
      8'h04: return mDir;
      8'h30: return mEn;
      8'h34: return mMask;
      8'h38: return mType;
      8'h3C: return mPol;
      8'h40: return modelRaw() & ~mMask;
      8'h44: return modelRaw();
      8'h50: return mSync;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [31:0] hit, ack, nEn, nType;
    if (!rstN) begin
      mOut = 0; mDir = 0; mEn = 0; mMask = 0; mType = 0; mPol = 0;
      mLatch = 0; mRd = 0; mSync = 0; mPrev = 0;
      padHist.delete();
      padHist.push_back(32'h0);
    end else begin
      hit = 0;
      for (int i = 0; i < 32; i++) begin
        if (mPol[i] && mSync[i] && !mPrev[i]) hit[i] = 1'b1;
        if (!mPol[i] && !mSync[i] && mPrev[i]) hit[i] = 1'b1;
      end
      ack = (busWrEn && busAddr == 8'h4C) ? busWdata : 32'h0;
      if (busRdEn) mRd = modelRead(busAddr);
      nEn = (busWrEn && busAddr == 8'h30) ? busWdata : mEn;
      nType = (busWrEn && busAddr == 8'h38) ? busWdata : mType;
      mLatch = ((mLatch & ~ack) | hit) & nEn & nType;
      if (busWrEn) begin
        case (busAddr)
          8'h00: mOut = busWdata;
          8'h04: mDir = busWdata;
          8'h34: mMask = busWdata;
          8'h3C: mPol = busWdata;
          default: ;
        endcase
      end
      mEn = nEn;
      mType = nType;
      mPrev = mSync;
      mSync = padHist[0];
      padHist.push_back(padIn);
      if (padHist.size() > 1) void'(padHist.pop_front());
    end
  end

  task automatic check(input string req, input string what,
                       input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2", "padOut", padOut, mOut);
      check("R2", "padOe", padOe, mDir);
      check("R9", "irqOut", {31'b0, irqOut}, {31'b0, |(modelRaw() & ~mMask)});
      check(tagNow, "busRdata", busRdata, mRd);
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 8'h00; busWdata = '0;
  endtask

  task automatic rd(input bit [7:0] a);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0; busAddr = 8'h00;
  endtask

  task automatic setPads(input bit [31:0] v);
    @(negedge clk);
    padIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "padOut after reset", padOut, 32'h0);
    check("R1", "padOe after reset", padOe, 32'h0);
    check("R1", "irqOut after reset", {31'b0, irqOut}, 32'h0);
    check("R1", "busRdata after reset", busRdata, 32'h0);
    rstN = 1'b1;
    foreach (modelRegs[i]) rd(modelRegs[i]);

    tagNow = "R2";
    wr(8'h00, 32'hA5A5_0F0F); rd(8'h00);
    wr(8'h04, 32'h0000_FFFF); rd(8'h04);
    wr(8'h00, 32'h1234_5678); rd(8'h00);

    tagNow = "R3";
    padIn = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    rd(8'h50);
    setPads(32'h0F0F_F0F0); rd(8'h50);

    tagNow = "R4";
    setPads(32'h0000_0000);
    wr(8'h3C, 32'h5555_5555);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    setPads(32'hFFFF_FFFF); rd(8'h44);
    setPads(32'h0000_0000); rd(8'h44); rd(8'h40);

    tagNow = "R6";
    wr(8'h4C, 32'h0000_FFFF); rd(8'h44);
    wr(8'h4C, 32'h0000_0000); rd(8'h44);
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h44);
    // ack sampled on the edge that latches a new rising event
    @(negedge clk); padIn = 32'h0000_0001;
    @(posedge clk); @(posedge clk);
    wr(8'h4C, 32'h0000_0001); rd(8'h44);

    tagNow = "R5";
    wr(8'h38, 32'h0000_0000);
    wr(8'h3C, 32'h0000_00FF);
    setPads(32'h0000_0F0F); rd(8'h44);
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h44);
    setPads(32'h0000_F0F0); rd(8'h44);

    tagNow = "R8";
    wr(8'h34, 32'h0000_00F0); rd(8'h40); rd(8'h44);
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h40);
    wr(8'h34, 32'h0000_0000); rd(8'h40);

    tagNow = "R7";
    wr(8'h38, 32'hFFFF_0000);
    wr(8'h3C, 32'hFFFF_0000);
    setPads(32'hFFFF_F0F0); rd(8'h44);
    wr(8'h30, 32'h00FF_00FF); rd(8'h44);
    wr(8'h30, 32'h0000_0000); rd(8'h44); rd(8'h40);
    setPads(32'h0000_0000); setPads(32'hFFFF_FFFF); rd(8'h44);

    tagNow = "R10";
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h78); rd(8'h4C); rd(8'h20);
    foreach (modelRegs[i]) rd(modelRegs[i]);

    tagNow = "R11";
    rd(8'h00);
    wr(8'h00, 32'h0BAD_F00D);
    repeat (3) @(negedge clk);
    rd(8'h00);

    repeat (4) @(negedge clk);
    finish();
  end

  bit [7:0] modelRegs [10] = '{8'h00, 8'h04, 8'h30, 8'h34, 8'h38,
                               8'h3C, 8'h40, 8'h44, 8'h4C, 8'h50};
endmodule